// File: doc/BRIEF.md
# Legacy Paravirtual Queue Register Bank

This block is the byte-addressed register file that a host driver uses to bring up a legacy paravirtual device. It sits on a plain host port that carries an address, an access size, write and read strobes and 32-bit data. Behind that port it keeps the host and guest feature words and a queue selector. It also keeps a page frame number for each queue, a read-only size for each queue, a device status byte and an 8-bit interrupt cause register that clears when read. Bit 0 of the cause register drives the interrupt line.

The device core sees three things. A notify pulse carries a queue index when the driver kicks a queue. A reset pulse follows a write of zero to the status byte. A lookup port returns the byte base address of any queue's ring. The core raises interrupt causes through a set input. Offsets at and above 20 form a device-specific configuration window, and accesses there are passed straight through to an external port.

The host port has no back-pressure. Each strobe is a single-cycle access that completes in its own cycle, and read data is valid while the read strobe is high. The notify and reset outputs are one-cycle pulses with no ready, so the core must accept them when they appear.

Top module: `vq_regbank`

## Requirements
- R1: A read at offset 0 returns the DEV_FEATURES parameter with bit 24 (notify-on-empty) and bit 30 (bad-feature) forced to 1. Writes to offset 0 change nothing.
- R2: A write at offset 4 stores the 32-bit guest feature word, and a read at offset 4 returns it. If bit 30 of the written value is 1, the stored word is FALLBACK_FEATURES when HAS_FALLBACK is 1, and 0 otherwise.
- R3: A write at offset 14 updates the queue selector only when wdata[15:0] is below NUM_QUEUES; otherwise the selector keeps its value. A read at offset 14 returns the selector, zero-extended.
- R4: A write at offset 8 stores wdata as the page frame number of the selected queue. A read at offset 8 returns the selected queue's frame number. core_base_o is the frame number of queue core_qidx_i shifted left by 12.
- R5: A read at offset 12 returns QUEUE_DEPTH for a selected queue below ACTIVE_QUEUES and 0 for any other queue. Writes to offset 12 change nothing.
- R6: A write at offset 16 makes notify_valid_o high for exactly the next cycle, with notify_queue_o equal to wdata[15:0]. A read at offset 16 returns all ones.
- R7: A write at offset 18 stores wdata[7:0] as the status byte, and a read at offset 18 returns it zero-extended.
- R8: A write of 0 to the status byte raises dev_reset_o for the next cycle. The same access clears the guest features, the queue selector, every queue's frame number and the interrupt cause register.
- R9: Each cycle, isr_set_i is ORed into the cause register. A read at offset 19 returns the current value and clears it, but bits set in the same cycle as that read are kept.
- R10: irq_o equals bit 0 of the cause register.
- R11: Reads of an offset below 20 that maps to no register, or of an offset at or past 20+CFG_LEN, return all ones. Writes to such offsets change no state.
- R12: For offsets 20 to 20+CFG_LEN-1, cfg_wr_o and cfg_rd_o follow the host strobes in the same cycle. The window also forwards cfg_offset_o (the address minus 20), the access size and the write data, and a read returns cfg_rdata_i.
- R13: After reset, every stored register is zero and irq_o, notify_valid_o and dev_reset_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr_i | input | ADDR_W | Byte offset of the access |
| host_size_i | input | 2 | Access size (0 byte, 1 half, 2 word), forwarded to the window |
| host_wr_i | input | 1 | Write strobe, one access per cycle |
| host_rd_i | input | 1 | Read strobe, one access per cycle |
| host_wdata_i | input | 32 | Write data |
| host_rdata_o | output | 32 | Read data, valid while host_rd_i is high |
| isr_set_i | input | 8 | Interrupt cause bits to set |
| irq_o | output | 1 | Interrupt line |
| notify_valid_o | output | 1 | Queue notify pulse |
| notify_queue_o | output | 16 | Queue index carried by the notify pulse |
| dev_reset_o | output | 1 | Device reset pulse |
| core_qidx_i | input | QSEL_W | Queue whose ring base is looked up |
| core_base_o | output | PFN_W+12 | Ring byte base of queue core_qidx_i |
| cfg_wr_o | output | 1 | Window write strobe |
| cfg_rd_o | output | 1 | Window read strobe |
| cfg_offset_o | output | ADDR_W | Offset inside the window |
| cfg_size_o | output | 2 | Forwarded access size |
| cfg_wdata_o | output | 32 | Forwarded write data |
| cfg_rdata_i | input | 32 | Window read data |

## Verification
The assertions check on every cycle that the forced feature bits appear, that all unmapped reads return ones, and that an out-of-range selector write leaves the selector alone. They also check that a notify write echoes its index on the next cycle, that a clearing read empties the cause register but keeps same-cycle sets, and that the interrupt line rises only after a set. The bench sweeps every selector value, every queue's frame number and size, and every offset in the address space. Those sweeps are the only way to show that the right queue is addressed, that a status reset wipes every queue and not just the selected one, and that the window forwards the correct offset.

// File: rtl/vq_regbank_pkg.sv
package vq_regbank_pkg;
  localparam int OFS_HOST_FEAT  = 0;
  localparam int OFS_GUEST_FEAT = 4;
  localparam int OFS_PFN        = 8;
  localparam int OFS_QSIZE      = 12;
  localparam int OFS_QSEL       = 14;
  localparam int OFS_NOTIFY     = 16;
  localparam int OFS_STATUS     = 18;
  localparam int OFS_ISR        = 19;
  localparam int OFS_CFG_BASE   = 20;

  localparam int BIT_NOTIFY_EMPTY = 24;
  localparam int BIT_BAD_FEATURE  = 30;

  typedef enum logic [3:0] {
    REG_NONE,
    REG_HOST_FEAT,
    REG_GUEST_FEAT,
    REG_PFN,
    REG_QSIZE,
    REG_QSEL,
    REG_NOTIFY,
    REG_STATUS,
    REG_ISR,
    REG_CFG
  } reg_sel_e;
endpackage

// File: rtl/vq_addr_decode.sv
module vq_addr_decode
  import vq_regbank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CFG_LEN = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [ADDR_W-1:0] cfg_off_o
);
  localparam int CFG_END = OFS_CFG_BASE + CFG_LEN;

  always_comb begin
    cfg_off_o = addr_i - ADDR_W'(OFS_CFG_BASE);
    if (int'(addr_i) >= OFS_CFG_BASE) begin
      sel_o = (int'(addr_i) < CFG_END) ? REG_CFG : REG_NONE;
    end else begin
      case (int'(addr_i))
        OFS_HOST_FEAT:  sel_o = REG_HOST_FEAT;
        OFS_GUEST_FEAT: sel_o = REG_GUEST_FEAT;
        OFS_PFN:        sel_o = REG_PFN;
        OFS_QSIZE:      sel_o = REG_QSIZE;
        OFS_QSEL:       sel_o = REG_QSEL;
        OFS_NOTIFY:     sel_o = REG_NOTIFY;
        OFS_STATUS:     sel_o = REG_STATUS;
        OFS_ISR:        sel_o = REG_ISR;
        default:        sel_o = REG_NONE;
      endcase
    end
  end
endmodule

// File: rtl/vq_queue_file.sv
module vq_queue_file #(
  parameter int NUM_QUEUES    = 64,
  parameter int ACTIVE_QUEUES = 2,
  parameter int QUEUE_DEPTH   = 256,
  parameter int PFN_W         = 32,
  parameter int PAGE_SHIFT    = 12,
  localparam int QSEL_W       = $clog2(NUM_QUEUES),
  localparam int BASE_W       = PFN_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [QSEL_W-1:0] wr_idx_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic [QSEL_W-1:0] rd_idx_i,
  output logic [PFN_W-1:0]  rd_pfn_o,
  output logic [15:0]       rd_size_o,
  input  logic [QSEL_W-1:0] core_idx_i,
  output logic [BASE_W-1:0] core_base_o
);
  logic [PFN_W-1:0] pfn_q [NUM_QUEUES];
  logic [NUM_QUEUES-1:0][15:0] size_tab;

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_size
    assign size_tab[g] = (g < ACTIVE_QUEUES) ? 16'(QUEUE_DEPTH) : 16'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_QUEUES; i++) pfn_q[i] <= '0;
    end else if (clear_i) begin
      for (int i = 0; i < NUM_QUEUES; i++) pfn_q[i] <= '0;
    end else if (wr_en_i) begin
      pfn_q[wr_idx_i] <= wr_pfn_i;
    end
  end

  assign rd_pfn_o    = pfn_q[rd_idx_i];
  assign rd_size_o   = size_tab[rd_idx_i];
  assign core_base_o = {pfn_q[core_idx_i], {PAGE_SHIFT{1'b0}}};

  AST_PFN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && !clear_i |=> pfn_q[$past(wr_idx_i)] == $past(wr_pfn_i)); // R4
  AST_PFN_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> rd_pfn_o == '0); // R8
endmodule

// File: rtl/vq_isr_reg.sv
module vq_isr_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] set_i,
  input  logic       clear_i,
  output logic [7:0] isr_o,
  output logic       irq_o
);
  logic [7:0] isr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (clear_i ? 8'h00 : isr_q) | set_i;
  end

  assign isr_o = isr_q;
  assign irq_o = isr_q[0];

  AST_ISR_EMPTIED: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i && set_i == 8'h00 |=> isr_q == 8'h00); // R9
  AST_ISR_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (isr_q & $past(set_i)) == $past(set_i)); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(set_i[0])); // R10
endmodule

// File: rtl/vq_regbank.sv
module vq_regbank
  import vq_regbank_pkg::*;
#(
  parameter int          ADDR_W            = 8,
  parameter int          NUM_QUEUES        = 64,
  parameter int          ACTIVE_QUEUES     = 2,
  parameter int          QUEUE_DEPTH       = 256,
  parameter int          PFN_W             = 32,
  parameter int          CFG_LEN           = 16,
  parameter logic [31:0] DEV_FEATURES      = 32'h0000_0020,
  parameter logic [31:0] FALLBACK_FEATURES = 32'h0000_0000,
  parameter bit          HAS_FALLBACK      = 1'b0,
  localparam int         PAGE_SHIFT        = 12,
  localparam int         QSEL_W            = $clog2(NUM_QUEUES),
  localparam int         BASE_W            = PFN_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [1:0]        host_size_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  input  logic [7:0]        isr_set_i,
  output logic              irq_o,
  output logic              notify_valid_o,
  output logic [15:0]       notify_queue_o,
  output logic              dev_reset_o,
  input  logic [QSEL_W-1:0] core_qidx_i,
  output logic [BASE_W-1:0] core_base_o,
  output logic              cfg_wr_o,
  output logic              cfg_rd_o,
  output logic [ADDR_W-1:0] cfg_offset_o,
  output logic [1:0]        cfg_size_o,
  output logic [31:0]       cfg_wdata_o,
  input  logic [31:0]       cfg_rdata_i
);
  localparam logic [31:0] FORCED_BITS =
    (32'd1 << BIT_NOTIFY_EMPTY) | (32'd1 << BIT_BAD_FEATURE);
  localparam logic [31:0] BAD_REPLACE = HAS_FALLBACK ? FALLBACK_FEATURES : 32'h0;

  reg_sel_e          sel;
  logic [ADDR_W-1:0] win_off;
  logic [31:0]       guest_q;
  logic [QSEL_W-1:0] qsel_q;
  logic [7:0]        status_q;
  logic [7:0]        isr_val;
  logic [PFN_W-1:0]  sel_pfn;
  logic [15:0]       sel_size;
  logic              do_reset, wr_notify, qsel_ok;

  vq_addr_decode #(.ADDR_W(ADDR_W), .CFG_LEN(CFG_LEN)) u_decode (
    .addr_i(host_addr_i), .sel_o(sel), .cfg_off_o(win_off)
  );

  assign do_reset  = host_wr_i && sel == REG_STATUS && host_wdata_i[7:0] == 8'h00;
  assign wr_notify = host_wr_i && sel == REG_NOTIFY;
  assign qsel_ok   = 32'(host_wdata_i[15:0]) < NUM_QUEUES;

  vq_queue_file #(
    .NUM_QUEUES(NUM_QUEUES), .ACTIVE_QUEUES(ACTIVE_QUEUES),
    .QUEUE_DEPTH(QUEUE_DEPTH), .PFN_W(PFN_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_queues (
    .clk(clk), .rst_n(rst_n), .clear_i(do_reset),
    .wr_en_i(host_wr_i && sel == REG_PFN), .wr_idx_i(qsel_q),
    .wr_pfn_i(host_wdata_i[PFN_W-1:0]), .rd_idx_i(qsel_q),
    .rd_pfn_o(sel_pfn), .rd_size_o(sel_size),
    .core_idx_i(core_qidx_i), .core_base_o(core_base_o)
  );

  vq_isr_reg u_isr (
    .clk(clk), .rst_n(rst_n), .set_i(isr_set_i),
    .clear_i((host_rd_i && sel == REG_ISR) || do_reset),
    .isr_o(isr_val), .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      guest_q        <= '0;
      qsel_q         <= '0;
      status_q       <= '0;
      notify_valid_o <= 1'b0;
      notify_queue_o <= '0;
      dev_reset_o    <= 1'b0;
    end else begin
      notify_valid_o <= wr_notify;
      dev_reset_o    <= do_reset;
      if (wr_notify) notify_queue_o <= host_wdata_i[15:0];
      if (host_wr_i && sel == REG_STATUS) status_q <= host_wdata_i[7:0];
      if (do_reset) begin
        guest_q <= '0;
        qsel_q  <= '0;
      end else begin
        if (host_wr_i && sel == REG_GUEST_FEAT)
          guest_q <= host_wdata_i[BIT_BAD_FEATURE] ? BAD_REPLACE : host_wdata_i;
        if (host_wr_i && sel == REG_QSEL && qsel_ok)
          qsel_q <= host_wdata_i[QSEL_W-1:0];
      end
    end
  end

  always_comb begin
    case (sel)
      REG_HOST_FEAT:  host_rdata_o = DEV_FEATURES | FORCED_BITS;
      REG_GUEST_FEAT: host_rdata_o = guest_q;
      REG_PFN:        host_rdata_o = 32'(sel_pfn);
      REG_QSIZE:      host_rdata_o = 32'(sel_size);
      REG_QSEL:       host_rdata_o = 32'(qsel_q);
      REG_STATUS:     host_rdata_o = 32'(status_q);
      REG_ISR:        host_rdata_o = 32'(isr_val);
      REG_CFG:        host_rdata_o = cfg_rdata_i;
      default:        host_rdata_o = 32'hFFFF_FFFF;
    endcase
  end

  assign cfg_wr_o     = host_wr_i && sel == REG_CFG;
  assign cfg_rd_o     = host_rd_i && sel == REG_CFG;
  assign cfg_offset_o = win_off;
  assign cfg_size_o   = host_size_i;
  assign cfg_wdata_o  = host_wdata_i;

  AST_FORCED_FEATURES: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_i && sel == REG_HOST_FEAT |-> host_rdata_o[BIT_NOTIFY_EMPTY] && host_rdata_o[BIT_BAD_FEATURE]); // R1
  AST_QSEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_i && sel == REG_QSEL && !qsel_ok |=> $stable(qsel_q)); // R3
  AST_NOTIFY_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_notify |=> notify_valid_o && notify_queue_o == $past(host_wdata_i[15:0])); // R6
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_o |-> status_q == 8'h00 && qsel_q == '0 && guest_q == '0); // R8
  AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_i && sel == REG_NONE |-> host_rdata_o == 32'hFFFF_FFFF); // R11
endmodule

// File: tb/vq_regbank_bench.sv
module vq_regbank_bench;
  localparam int NQ = 4, ACTQ = 2, DEPTH = 256, CLEN = 8;
  localparam logic [31:0] DEVF = 32'h0000_1234, FALLF = 32'h0000_0011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [1:0] size = 2'd2;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0] iset = '0;
  logic irq, nvalid, dreset, cwr, crd;
  logic [15:0] nqueue;
  logic [1:0] cidx = '0, csize;
  logic [43:0] cbase;
  logic [7:0] coff;
  logic [31:0] cwdata, crdata;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;
  assign crdata = 32'hC0DE_0000 | 32'(coff);

  vq_regbank #(
    .NUM_QUEUES(NQ), .ACTIVE_QUEUES(ACTQ), .QUEUE_DEPTH(DEPTH), .CFG_LEN(CLEN),
    .DEV_FEATURES(DEVF), .FALLBACK_FEATURES(FALLF), .HAS_FALLBACK(1'b1)
  ) u_vq_regbank (
    .clk(clk), .rst_n(rst_n), .host_addr_i(addr), .host_size_i(size),
    .host_wr_i(wr), .host_rd_i(rd), .host_wdata_i(wdata), .host_rdata_o(rdata),
    .isr_set_i(iset), .irq_o(irq), .notify_valid_o(nvalid), .notify_queue_o(nqueue),
    .dev_reset_o(dreset), .core_qidx_i(cidx), .core_base_o(cbase),
    .cfg_wr_o(cwr), .cfg_rd_o(crd), .cfg_offset_o(coff), .cfg_size_o(csize),
    .cfg_wdata_o(cwdata), .cfg_rdata_i(crdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write: returns at the negedge after the capturing edge
  task automatic hwr(input int a, input logic [31:0] d);
    @(negedge clk); addr = 8'(a); wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic hrd(input int a, input logic [7:0] s, output logic [31:0] d);
    @(negedge clk); addr = 8'(a); rd = 1'b1; iset = s;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0; iset = '0;
  endtask

  function automatic bit mapped(input int a);
    return a == 0 || a == 4 || a == 8 || a == 12 || a == 14 || a == 18 || a == 19 ||
           (a >= 20 && a < 20 + CLEN);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp_sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    chk("R13 irq", 64'(irq), 0); chk("R13 notify", 64'(nvalid), 0); chk("R13 reset", 64'(dreset), 0);
    hrd(4, 0, d);  chk("R13 guest", 64'(d), 0);
    hrd(14, 0, d); chk("R13 qsel", 64'(d), 0);
    hrd(18, 0, d); chk("R13 status", 64'(d), 0);
    hrd(19, 0, d); chk("R13 isr", 64'(d), 0);
    // R1
    hrd(0, 0, d); chk("R1 host features", 64'(d), 64'(DEVF | 32'h4100_0000));
    hwr(0, 32'h0);
    hrd(0, 0, d); chk("R1 read-only", 64'(d), 64'(DEVF | 32'h4100_0000));
    // R2
    hwr(4, 32'h0000_00FF); hrd(4, 0, d); chk("R2 guest store", 64'(d), 64'h00FF);
    hwr(4, 32'h4000_0005); hrd(4, 0, d); chk("R2 bad fallback", 64'(d), 64'(FALLF));
    // R3 selector sweep
    exp_sel = 0;
    for (int v = 0; v < 8; v++) begin
      hwr(14, 32'(v + 16'h100 * (v / 6)));
      if (v < NQ) exp_sel = 32'(v);
      hrd(14, 0, d); chk("R3 queue select", 64'(d), 64'(exp_sel));
    end
    // R4 / R5 per-queue sweep
    for (int q = 0; q < NQ; q++) begin
      hwr(14, 32'(q)); hwr(8, 32'h000A_0000 + 32'(q) * 32'h111);
    end
    for (int q = 0; q < NQ; q++) begin
      hwr(14, 32'(q));
      hwr(12, 32'hFFFF);
      hrd(8, 0, d);  chk("R4 pfn readback", 64'(d), 64'(32'h000A_0000 + 32'(q) * 32'h111));
      hrd(12, 0, d); chk("R5 queue size", 64'(d), (q < ACTQ) ? 64'(DEPTH) : 64'd0);
      cidx = 2'(q); #1;
      chk("R4 ring base", 64'(cbase), 64'(32'h000A_0000 + 32'(q) * 32'h111) << 12);
    end
    // R6 notify
    hwr(16, 32'h0002_0003);
    chk("R6 notify pulse", 64'(nvalid), 1); chk("R6 notify index", 64'(nqueue), 64'h0003);
    @(negedge clk); chk("R6 pulse width", 64'(nvalid), 0);
    hrd(16, 0, d); chk("R6 notify read", 64'(d), 64'hFFFF_FFFF);
    // R7 status
    hwr(18, 32'h0000_01F7); chk("R7 no reset", 64'(dreset), 0);
    hrd(18, 0, d); chk("R7 status", 64'(d), 64'h00F7);
    // R9 / R10 interrupt cause
    @(negedge clk); iset = 8'h05; @(negedge clk); iset = 8'h00;
    chk("R10 irq high", 64'(irq), 1);
    hrd(19, 0, d); chk("R9 isr value", 64'(d), 64'h05);
    chk("R10 irq cleared", 64'(irq), 0);
    hrd(19, 0, d); chk("R9 isr empty", 64'(d), 0);
    @(negedge clk); iset = 8'h01; @(negedge clk); iset = 8'h00;
    hrd(19, 8'h02, d); chk("R9 race read", 64'(d), 64'h01);
    chk("R10 irq after race", 64'(irq), 0);
    hrd(19, 8'h01, d); chk("R9 set kept", 64'(d), 64'h02);
    chk("R10 irq kept", 64'(irq), 1);
    // R8 status reset (isr bit0 pending, queue 3 selected)
    hwr(18, 32'h0000_0000);
    chk("R8 reset pulse", 64'(dreset), 1); chk("R10 irq wiped", 64'(irq), 0);
    @(negedge clk); chk("R8 pulse width", 64'(dreset), 0);
    hrd(4, 0, d);  chk("R8 guest cleared", 64'(d), 0);
    hrd(14, 0, d); chk("R8 qsel cleared", 64'(d), 0);
    hrd(19, 0, d); chk("R8 isr cleared", 64'(d), 0);
    for (int q = 0; q < NQ; q++) begin
      hwr(14, 32'(q)); hrd(8, 0, d); chk("R8 pfn cleared", 64'(d), 0);
    end
    // R11 address sweep
    hwr(4, 32'h0000_0077);
    for (int a = 0; a < 40; a++) begin
      if (!mapped(a) && a != 16) begin
        hwr(a, 32'h0);
        hrd(a, 0, d); chk("R11 unmapped read", 64'(d), 64'hFFFF_FFFF);
      end
    end
    hrd(4, 0, d); chk("R11 writes ignored", 64'(d), 64'h0077);
    // R12 config window
    for (int k = 0; k < CLEN; k++) begin
      @(negedge clk); addr = 8'(20 + k); rd = 1'b1; #1;
      chk("R12 window read", 64'(rdata), 64'(32'hC0DE_0000 | 32'(k)));
      chk("R12 read strobe", 64'({crd, coff}), 64'({1'b1, 8'(k)}));
      @(negedge clk); rd = 1'b0;
    end
    @(negedge clk); addr = 8'd23; size = 2'd1; wdata = 32'hABCD_1234; wr = 1'b1; #1;
    chk("R12 window write", 64'({cwr, coff, csize, cwdata}), 64'({1'b1, 8'd3, 2'd1, 32'hABCD_1234}));
    @(negedge clk); wr = 1'b0; size = 2'd2;
    @(negedge clk); addr = 8'(20 + CLEN); rd = 1'b1; #1;
    chk("R12 past window", 64'({crd, rdata}), 64'({1'b0, 32'hFFFF_FFFF}));
    @(negedge clk); rd = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule